// File: doc/BRIEF.md
# Windowed Command and Interrupt Controller

This block is the host-facing control core of a network adapter. The host writes 16-bit words to a single command port. Each word carries an opcode and an argument. The block decodes the word into actions:
- select which register bank (window) the host sees,
- turn the receiver and the transmitter on or off,
- issue reset strobes,
- acknowledge interrupt events, raise one on demand, or load the interrupt mask.

Reads of the same port see a composite status word that carries the current window, a busy flag and eight event latches.

Transmit and receive logic report events as one-cycle pulses. The block holds each event in a latch until the host acknowledges it. It combines the latches with the enable mask to drive one interrupt request line. A global reset command clears the control state and keeps the busy flag asserted for a programmable hold time. Any command written while busy is dropped and recorded in a sticky error flag.

Top module: `win_cmd_ctrl`

## Requirements
- R1: `stat_o` is `{window[2:0], busy, 4'b0000, latch[7:0]}`. After `rst_ni` every field is zero, the receiver and transmitter are off, and the mask is zero.
- R2: Every command takes effect on the clock edge at which `cmd_we_i` is high. The opcode is `cmd_word_i[15:11]` and the argument is `cmd_word_i[10:0]`. Opcode 1 loads the window from argument bits 2..0, and the other argument bits are ignored.
- R3: Opcode 4 turns the receiver on (`rx_on_o`=1). Opcodes 3 and 5 turn it off. It stays off after reset until opcode 4.
- R4: Opcode 9 turns the transmitter on (`tx_on_o`=1). Opcodes 10 and 11 turn it off.
- R5: Opcode 5 pulses `rx_rst_o` and opcode 11 pulses `tx_rst_o`, each for one cycle after the accepting edge.
- R6: `evt_i` bits 0..4 set latch bits 1..5 and `evt_i` bit 5 sets latch bit 7. A set wins over an acknowledge in the same cycle.
- R7: Opcode 13 clears every latch bit whose argument bit (7..0) is one.
- R8: Opcode 12 sets latch bit 6. Opcode 14 loads the mask from argument bits 7..0.
- R9: Latch bit 0 sets on the edge at which any masked latch bit among 7..1 is pending. It is cleared only by acknowledge or reset.
- R10: `irq_o` is high exactly when some latch bit and the same mask bit are both one.
- R11: Opcode 0 clears window, latches, mask, receiver, transmitter and error. It pulses `glb_rst_o` and holds busy for HOLD_CYC cycles.
- R12: While busy, a command changes nothing and sets `cmd_err_o`. That flag is cleared only by an accepted opcode 0 or `rst_ni`.
- R13: Opcodes 2, 6, 7, 8 and 15..31 change no state and pulse no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command port write strobe |
| cmd_word_i | input | 16 | Command word: opcode and argument |
| evt_i | input | 6 | Event pulses from the transmit and receive logic |
| stat_o | output | 16 | Composite status word |
| irq_o | output | 1 | Interrupt request |
| win_o | output | 3 | Current window |
| rx_on_o | output | 1 | Receiver enabled |
| tx_on_o | output | 1 | Transmitter enabled |
| rx_rst_o | output | 1 | Receiver reset strobe |
| tx_rst_o | output | 1 | Transmitter reset strobe |
| glb_rst_o | output | 1 | Global reset strobe |
| cmd_err_o | output | 1 | Sticky dropped-command flag |

## Verification
The hardest case to reach is a write that lands inside the busy window after a global reset. The write must be dropped and the error must survive both the end of the hold and later accepted commands. The stimulus issues opcode 0 and then writes a window select two cycles later. It then writes another window select after busy has fallen, and only then issues a second opcode 0, which must clear the flag. A second hard case is an event pulse on the same edge as its own acknowledge. The bench drives both on the same edge from one task. A long random phase then mixes every opcode, rare global resets and sparse events, and checks each edge against a behavioural model.

// File: rtl/wcc_pkg.sv
package wcc_pkg;
  localparam int WORD_W = 16;
  localparam int OPC_W  = 5;
  localparam int ARG_W  = WORD_W - OPC_W;
  localparam int WIN_W  = 3;
  localparam int EVT_W  = 8;
  localparam int HW_EVT_W = 6;
  localparam int PAD_W  = WORD_W - WIN_W - 1 - EVT_W;

  typedef enum logic [OPC_W-1:0] {
    OP_GLB_RST = 5'd0,
    OP_WIN     = 5'd1,
    OP_RX_OFF  = 5'd3,
    OP_RX_ON   = 5'd4,
    OP_RX_RST  = 5'd5,
    OP_TX_ON   = 5'd9,
    OP_TX_OFF  = 5'd10,
    OP_TX_RST  = 5'd11,
    OP_REQ     = 5'd12,
    OP_ACK     = 5'd13,
    OP_MASK    = 5'd14
  } opc_e;

  typedef struct packed {
    logic glb_rst;
    logic win_sel;
    logic rx_off;
    logic rx_on;
    logic rx_rst;
    logic tx_on;
    logic tx_off;
    logic tx_rst;
    logic req_irq;
    logic ack;
    logic mask_ld;
  } cmd_t;
endpackage

// File: rtl/wcc_cmd_decode.sv
module wcc_cmd_decode
  import wcc_pkg::*;
(
  input  logic              wr_i,
  input  logic              busy_i,
  input  logic [WORD_W-1:0] word_i,
  output cmd_t              cmd_o,
  output logic [EVT_W-1:0]  arg_o,
  output logic              drop_o
);
  logic [OPC_W-1:0] opc;
  logic             take;
  logic             unused_arg_hi;

  assign opc           = word_i[WORD_W-1 -: OPC_W];
  assign arg_o         = word_i[EVT_W-1:0];
  assign unused_arg_hi = ^word_i[ARG_W-1:EVT_W];
  assign take          = wr_i & ~busy_i;
  assign drop_o        = wr_i & busy_i;

  always_comb begin
    cmd_o = '0;
    if (take) begin
      case (opc)
        OP_GLB_RST: cmd_o.glb_rst = 1'b1;
        OP_WIN:     cmd_o.win_sel = 1'b1;
        OP_RX_OFF:  cmd_o.rx_off  = 1'b1;
        OP_RX_ON:   cmd_o.rx_on   = 1'b1;
        OP_RX_RST:  cmd_o.rx_rst  = 1'b1;
        OP_TX_ON:   cmd_o.tx_on   = 1'b1;
        OP_TX_OFF:  cmd_o.tx_off  = 1'b1;
        OP_TX_RST:  cmd_o.tx_rst  = 1'b1;
        OP_REQ:     cmd_o.req_irq = 1'b1;
        OP_ACK:     cmd_o.ack     = 1'b1;
        OP_MASK:    cmd_o.mask_ld = 1'b1;
        default:    cmd_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/wcc_hold_timer.sv
module wcc_hold_timer #(
  parameter int unsigned HOLD_CYC = 250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(HOLD_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= CNT_INIT;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  AST_BUSY_FROM_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(load_i)); // R11
endmodule

// File: rtl/wcc_evt_latch.sv
module wcc_evt_latch
  import wcc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [EVT_W-1:1] set_i,
  input  logic [EVT_W-1:0] ack_i,
  input  logic             mask_we_i,
  input  logic [EVT_W-1:0] mask_d_i,
  output logic [EVT_W-1:0] lat_o,
  output logic             irq_o
);
  logic [EVT_W-1:0] lat_q, lat_d, mask_q;
  logic             hit;

  for (genvar k = 1; k < EVT_W; k++) begin : g_bit
    assign lat_d[k] = ~clr_i & (set_i[k] | (lat_q[k] & ~ack_i[k]));

    AST_EVT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] && !clr_i |=> lat_q[k]); // R6
    AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_i[k] && !set_i[k] |=> !lat_q[k]); // R7
  end

  // summary bit follows the next value of the masked event bits
  assign hit      = |(lat_d[EVT_W-1:1] & mask_q[EVT_W-1:1]);
  assign lat_d[0] = ~clr_i & ((lat_q[0] & ~ack_i[0]) | hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q  <= '0;
      mask_q <= '0;
    end else begin
      lat_q <= lat_d;
      if (clr_i)          mask_q <= '0;
      else if (mask_we_i) mask_q <= mask_d_i;
    end
  end

  assign lat_o = lat_q;
  assign irq_o = |(lat_q & mask_q);

  AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i && !clr_i |=> mask_q == $past(mask_d_i)); // R8
endmodule

// File: rtl/win_cmd_ctrl.sv
module win_cmd_ctrl
  import wcc_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 250000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_we_i,
  input  logic [WORD_W-1:0]   cmd_word_i,
  input  logic [HW_EVT_W-1:0] evt_i,
  output logic [WORD_W-1:0]   stat_o,
  output logic                irq_o,
  output logic [WIN_W-1:0]    win_o,
  output logic                rx_on_o,
  output logic                tx_on_o,
  output logic                rx_rst_o,
  output logic                tx_rst_o,
  output logic                glb_rst_o,
  output logic                cmd_err_o
);
  cmd_t             cmd;
  logic [EVT_W-1:0] arg;
  logic             drop, busy;
  logic [EVT_W-1:0] lat, ack;
  logic [EVT_W-1:1] set;
  logic [WIN_W-1:0] win_q;
  logic             rx_q, tx_q, err_q, grst_q, rrst_q, trst_q;

  wcc_cmd_decode u_dec (
    .wr_i   (cmd_we_i),
    .busy_i (busy),
    .word_i (cmd_word_i),
    .cmd_o  (cmd),
    .arg_o  (arg),
    .drop_o (drop)
  );

  wcc_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cmd.glb_rst),
    .busy_o (busy)
  );

  assign set = {evt_i[HW_EVT_W-1], cmd.req_irq, evt_i[HW_EVT_W-2:0]};
  assign ack = cmd.ack ? arg : '0;

  wcc_evt_latch u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (cmd.glb_rst),
    .set_i     (set),
    .ack_i     (ack),
    .mask_we_i (cmd.mask_ld),
    .mask_d_i  (arg),
    .lat_o     (lat),
    .irq_o     (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      rx_q   <= 1'b0;
      tx_q   <= 1'b0;
      err_q  <= 1'b0;
      grst_q <= 1'b0;
      rrst_q <= 1'b0;
      trst_q <= 1'b0;
    end else begin
      grst_q <= cmd.glb_rst;
      rrst_q <= cmd.rx_rst;
      trst_q <= cmd.tx_rst;
      if (cmd.glb_rst)      win_q <= '0;
      else if (cmd.win_sel) win_q <= arg[WIN_W-1:0];
      if (cmd.glb_rst || cmd.rx_off || cmd.rx_rst) rx_q <= 1'b0;
      else if (cmd.rx_on)                          rx_q <= 1'b1;
      if (cmd.glb_rst || cmd.tx_off || cmd.tx_rst) tx_q <= 1'b0;
      else if (cmd.tx_on)                          tx_q <= 1'b1;
      if (cmd.glb_rst) err_q <= 1'b0;
      else if (drop)   err_q <= 1'b1;
    end
  end

  assign stat_o    = {win_q, busy, {PAD_W{1'b0}}, lat};
  assign win_o     = win_q;
  assign rx_on_o   = rx_q;
  assign tx_on_o   = tx_q;
  assign rx_rst_o  = rrst_q;
  assign tx_rst_o  = trst_q;
  assign glb_rst_o = grst_q;
  assign cmd_err_o = err_q;

  AST_BUSY_FREEZES_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && cmd_we_i |=> $stable(win_o)); // R12
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err_o && !cmd.glb_rst |=> cmd_err_o); // R12
  AST_RX_RST_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rst_o |-> !rx_on_o); // R5
  AST_GRST_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glb_rst_o |-> stat_o[WORD_W-WIN_W-1] && !cmd_err_o); // R11
endmodule

// File: tb/win_cmd_ctrl_test.sv
`timescale 1ns/1ps
module win_cmd_ctrl_test;
  localparam int HOLD = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [15:0] word = '0;
  logic [5:0]  evt = '0;
  logic [15:0] stat;
  logic        irq, rx_on, tx_on, rx_rst, tx_rst, glb_rst, err;
  logic [2:0]  win;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  win_cmd_ctrl #(.HOLD_CYC(HOLD)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(we), .cmd_word_i(word), .evt_i(evt),
    .stat_o(stat), .irq_o(irq), .win_o(win), .rx_on_o(rx_on), .tx_on_o(tx_on),
    .rx_rst_o(rx_rst), .tx_rst_o(tx_rst), .glb_rst_o(glb_rst), .cmd_err_o(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [2:0] m_win;
  int         m_cnt;
  logic [7:0] m_lat, m_mask;
  bit         m_rx, m_tx, m_err, m_grst, m_rrst, m_trst;
  logic [7:0] t_nl, t_ack, t_set;
  bit         t_clr, t_mwe;
  int         t_opc;
  logic [7:0] t_arg;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_win = 0; m_cnt = 0; m_lat = 0; m_mask = 0;
      m_rx = 0; m_tx = 0; m_err = 0; m_grst = 0; m_rrst = 0; m_trst = 0;
    end else begin
      t_opc = int'(word[15:11]);
      t_arg = word[7:0];
      t_clr = 0; t_mwe = 0; t_ack = 0;
      t_set = {evt[5], 1'b0, evt[4:0], 1'b0};
      m_grst = 0; m_rrst = 0; m_trst = 0;
      if (we && m_cnt > 0) begin
        m_err = 1;
        m_cnt = m_cnt - 1;
      end else begin
        if (m_cnt > 0) m_cnt = m_cnt - 1;
        if (we) begin
          case (t_opc)
            0: begin
              t_clr = 1; m_grst = 1; m_cnt = HOLD;
              m_win = 0; m_rx = 0; m_tx = 0; m_err = 0;
            end
            1:  m_win = t_arg[2:0];
            3:  m_rx = 0;
            4:  m_rx = 1;
            5:  begin m_rx = 0; m_rrst = 1; end
            9:  m_tx = 1;
            10: m_tx = 0;
            11: begin m_tx = 0; m_trst = 1; end
            12: t_set[6] = 1'b1;
            13: t_ack = t_arg;
            14: t_mwe = 1;
            default: ;
          endcase
        end
      end
      for (int k = 1; k < 8; k++)
        t_nl[k] = t_clr ? 1'b0 : (t_set[k] | (m_lat[k] & ~t_ack[k]));
      t_nl[0] = t_clr ? 1'b0 : ((m_lat[0] & ~t_ack[0]) | (|(t_nl[7:1] & m_mask[7:1])));
      m_lat = t_nl;
      if (t_clr) m_mask = 0;
      else if (t_mwe) m_mask = t_arg;
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R1 status word", stat, {m_win, (m_cnt > 0) ? 1'b1 : 1'b0, 4'b0000, m_lat});
      chk("R2 window", win, m_win);
      chk("R3 rx_on", rx_on, m_rx);
      chk("R4 tx_on", tx_on, m_tx);
      chk("R5 rx_rst", rx_rst, m_rrst);
      chk("R5 tx_rst", tx_rst, m_trst);
      chk("R10 irq", irq, |(m_lat & m_mask));
      chk("R11 glb_rst", glb_rst, m_grst);
      chk("R12 err", err, m_err);
    end
  end

  task automatic cmd(input logic [4:0] opc, input logic [10:0] arg);
    @(negedge clk); we = 1'b1; word = {opc, arg};
    @(negedge clk); we = 1'b0; word = '0;
  endtask

  task automatic pulse(input logic [5:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] snap;
    bit          s_rx, s_tx;
    int          busy_cyc;
    repeat (3) @(negedge clk);
    chk("R1 reset status", stat, 0);
    chk("R3 reset rx off", rx_on, 0);
    chk("R10 reset irq", irq, 0);
    rst_n = 1'b1;
    idle(2);

    cmd(5'd1, 11'h7FD);
    chk("R2 window from low bits", win, 5);
    chk("R1 window in status", stat[15:13], 5);
    cmd(5'd4, 11'h0);  chk("R3 rx on", rx_on, 1);
    cmd(5'd3, 11'h0);  chk("R3 rx off", rx_on, 0);
    cmd(5'd4, 11'h0);
    cmd(5'd5, 11'h0);  chk("R5 rx reset leaves rx off", rx_on, 0);
    cmd(5'd9, 11'h0);  chk("R4 tx on", tx_on, 1);
    cmd(5'd10, 11'h0); chk("R4 tx off", tx_on, 0);
    cmd(5'd9, 11'h0);
    cmd(5'd11, 11'h0); chk("R4 tx reset off", tx_on, 0);
    cmd(5'd9, 11'h0);
    cmd(5'd4, 11'h0);

    pulse(6'b000001);
    chk("R6 event0 to bit1", stat[7:0], 8'h02);
    chk("R9 no bit0 while unmasked", stat[0], 0);
    cmd(5'd14, 11'h002);
    chk("R10 irq after mask", irq, 1);
    idle(1);
    chk("R9 summary bit sets", stat[0], 1);
    cmd(5'd13, 11'h002);
    chk("R7 ack clears bit1", stat[7:0], 8'h01);
    cmd(5'd13, 11'h001);
    chk("R7 ack clears bit0", stat[7:0], 8'h00);
    chk("R10 irq low", irq, 0);

    @(negedge clk); we = 1'b1; word = {5'd13, 11'h008}; evt = 6'b000100;
    @(negedge clk); we = 1'b0; word = '0; evt = '0;
    chk("R6 set wins over ack", stat[3], 1);
    pulse(6'b100000);
    chk("R6 event5 to bit7", stat[7], 1);
    cmd(5'd12, 11'h0);
    chk("R8 requested bit6", stat[6], 1);
    cmd(5'd14, 11'h040);
    chk("R8 mask bit6 drives irq", irq, 1);
    cmd(5'd13, 11'h0FF);

    snap = stat; s_rx = rx_on; s_tx = tx_on;
    foreach (snap[i]) begin end
    cmd(5'd2, 11'h7FF); cmd(5'd6, 11'h7FF); cmd(5'd7, 11'h7FF);
    cmd(5'd8, 11'h7FF); cmd(5'd15, 11'h7FF); cmd(5'd31, 11'h7FF);
    chk("R13 unknown ops keep status", stat, snap);
    chk("R13 unknown ops keep rx", rx_on, s_rx);
    chk("R13 unknown ops keep tx", tx_on, s_tx);
    chk("R13 no strobes", {glb_rst, rx_rst, tx_rst}, 0);

    cmd(5'd1, 11'h006);
    cmd(5'd0, 11'h0);
    chk("R11 global reset status", stat, 16'h1000);
    chk("R11 global reset rx/tx off", {rx_on, tx_on}, 0);
    cmd(5'd1, 11'h003);
    chk("R12 busy write dropped", win, 0);
    chk("R12 error set", err, 1);
    idle(HOLD);
    cmd(5'd1, 11'h002);
    chk("R12 accepted after busy", win, 2);
    chk("R12 error sticky", err, 1);
    cmd(5'd0, 11'h0);
    chk("R12 global reset clears error", err, 0);
    busy_cyc = 0;
    while (stat[12] && busy_cyc < 1000) begin
      busy_cyc++;
      @(negedge clk);
    end
    chk("R11 busy hold length", busy_cyc, HOLD);

    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      we = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 60) == 0) word = {5'd0, 11'($urandom)};
      else if ($urandom_range(0, 5) == 0) word = 16'($urandom);
      else word = {5'($urandom_range(1, 15)), 11'($urandom)};
      evt = ($urandom_range(0, 3) == 0) ? 6'($urandom) : 6'd0;
    end
    @(negedge clk); we = 1'b0; evt = '0;
    idle(HOLD + 2);
    finish_run();
  end
endmodule